// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block orders the start-up of a switching regulator controller once the regulator is enabled and the analog supply is above its lockout threshold. The controller first fires one low-side gate pulse, which charges the bootstrap capacitor. The block then raises the allowed current limit in equal steps. Each step lasts a fixed number of switching cycles. The block learns that a cycle has passed from a one-clock strobe, and it counts only those strobes, so time measured in clock ticks plays no part.

During the first step the sequencer asks for a doubled minimum off-time and a positive offset on the sensed output for on-time purposes. Both requests help the output come up from zero. After the last step the sequencer raises a completion flag. That flag arms the under-voltage and power-good logic. The current-limit code stays at full scale until the run condition is lost.

The run condition is enable AND supply-OK. If either input drops, the sequencer returns to idle at the next clock, clears its counters and releases the drivers. A new run always starts again with the precharge pulse.

Top module: `ss_sequencer`

## Requirements
- R1: After synchronous reset, and in the idle state, all outputs are 0: `drv_en`, `lo_precharge`, `ilim_code`, `dbl_toff`, `ofs_req` and `ss_done`.
- R2: When idle and `en` and `supply_ok` are both 1 at a clock edge, the block enters the precharge state at that edge. In this state `drv_en`=1, `lo_precharge`=1, `ilim_code`=0, `ss_done`=0, and `dbl_toff`=`ofs_req`=0.
- R3: In precharge, the first edge with `cyc_tick`=1 ends precharge. That tick is not counted toward the ramp. The block enters ramp step 0, where `ilim_code`=0 (quarter limit), `dbl_toff`=1 and `ofs_req`=1.
- R4: In the ramp, every 110 counted ticks advance `ilim_code` by one: 0, then 1, then 2, then 3, encoding 25/50/75/100 % of the limit. `dbl_toff` and `ofs_req` are 1 only during step 0.
- R5: At the edge of the 440th counted tick, `ss_done` becomes 1 and `ilim_code` becomes 3. After that, `dbl_toff`=`ofs_req`=`lo_precharge`=0, and this state holds while `en` and `supply_ok` stay 1.
- R6: Clock edges with `cyc_tick`=0 advance neither the step nor the count within the step.
- R7: An edge where `en`=0 or `supply_ok`=0 returns the block to idle, whatever its state and whatever the value of `cyc_tick`. The count is cleared, so a later run repeats precharge and all 440 ticks.
- R8: `drv_en` is 0 exactly when the block is idle. While supply-OK is low the drivers are therefore released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock strobe per switching cycle |
| en | input | 1 | Regulator enable |
| supply_ok | input | 1 | Analog supply above lockout (hysteretic comparator result) |
| drv_en | output | 1 | Gate drivers active (0 = tri-stated) |
| lo_precharge | output | 1 | Request the initial low-side bootstrap pulse |
| ilim_code | output | 2 | Current-limit scale code, 0..3 |
| dbl_toff | output | 1 | Double minimum off-time request |
| ofs_req | output | 1 | Startup on-time offset request |
| ss_done | output | 1 | Sequence complete; arms under-voltage and power-good |

## Verification
The hardest point to reach is a loss of enable or supply at the exact tick where one step hands over to the next, or a few ticks before completion, followed by a clean restart. Sparse random ticks alone rarely land there. Directed runs therefore stop ticks right at the step boundaries. They also drop `supply_ok` one tick short of completion and then re-enable, and they hold ticks low for long stretches in the middle of a step. A long randomized phase then mixes tick densities with rare drops of either input. In both phases every output is compared on every cycle against a bench model.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_BOOT = 2'd1,
    SS_RAMP = 2'd2,
    SS_DONE = 2'd3
  } ss_state_t;
endpackage

// File: rtl/ss_cycle_counter.sv
module ss_cycle_counter #(
  parameter int STEP_CYCLES = 110,
  localparam int CW = $clog2(STEP_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic last
);
  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(STEP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (adv) begin
      if (last) cnt <= '0;
      else      cnt <= cnt + CW'(1);
    end
  end

  // R4: the count never passes the end of a step
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(STEP_CYCLES - 1));
  // R6: without a counted tick the count holds
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt));
endmodule

// File: rtl/ss_step_fsm.sv
module ss_step_fsm
  import ss_pkg::*;
#(
  parameter int NUM_STEPS = 4,
  localparam int SW = $clog2(NUM_STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          last,
  output ss_state_t     state,
  output logic [SW-1:0] step
);
  localparam logic [SW-1:0] STEP_MAX = SW'(NUM_STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      state <= SS_IDLE;
      step  <= '0;
    end else begin
      case (state)
        SS_IDLE: state <= SS_BOOT;
        SS_BOOT: if (tick) begin
          state <= SS_RAMP;
          step  <= '0;
        end
        SS_RAMP: if (tick && last) begin
          if (step == STEP_MAX) state <= SS_DONE;
          else                  step  <= step + SW'(1);
        end
        default: state <= SS_DONE;
      endcase
    end
  end

  // R7: loss of run returns to idle with the step cleared
  p_idle_after_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (state == SS_IDLE && step == '0));
  // R3: ramp is entered only from precharge on a tick, at step 0
  p_ramp_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (state == SS_RAMP && $past(state) != SS_RAMP) |->
      ($past(state) == SS_BOOT && $past(tick) && step == '0));
  // R4: steps advance by one, only on the last tick of a step
  p_step_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (state == SS_RAMP && $past(state) == SS_RAMP && step != $past(step)) |->
      (step == $past(step) + SW'(1) && $past(tick) && $past(last)));
  // R5: completion holds while running
  p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state == SS_DONE && run) |=> state == SS_DONE);
endmodule

// File: rtl/ss_out_decode.sv
module ss_out_decode
  import ss_pkg::*;
#(
  parameter int NUM_STEPS = 4,
  localparam int SW = $clog2(NUM_STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  ss_state_t     state,
  input  logic [SW-1:0] step,
  output logic          drv_en,
  output logic          lo_precharge,
  output logic [SW-1:0] ilim_code,
  output logic          dbl_toff,
  output logic          ofs_req,
  output logic          ss_done
);
  localparam logic [SW-1:0] CODE_MAX = SW'(NUM_STEPS - 1);

  always_comb begin
    drv_en       = (state != SS_IDLE);
    lo_precharge = (state == SS_BOOT);
    ss_done      = (state == SS_DONE);
    dbl_toff     = (state == SS_RAMP) && (step == '0);
    ofs_req      = dbl_toff;
    case (state)
      SS_RAMP: ilim_code = step;
      SS_DONE: ilim_code = CODE_MAX;
      default: ilim_code = '0;
    endcase
  end

  // R5: completion always carries full-scale limit
  p_done_code_r5: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> (ilim_code == CODE_MAX && !dbl_toff && !lo_precharge));
  // R4: startup aids only at the quarter-limit step
  p_aid_first_r4: assert property (@(posedge clk) disable iff (rst)
    (dbl_toff || ofs_req) |-> (ilim_code == '0 && drv_en && !ss_done));
  // R8: released drivers imply a quiet sequencer
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !drv_en |-> (ilim_code == '0 && !ss_done && !lo_precharge && !dbl_toff));
endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer
  import ss_pkg::*;
#(
  parameter int STEP_CYCLES = 110,
  parameter int NUM_STEPS   = 4,
  localparam int SW = $clog2(NUM_STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_tick,
  input  logic          en,
  input  logic          supply_ok,
  output logic          drv_en,
  output logic          lo_precharge,
  output logic [SW-1:0] ilim_code,
  output logic          dbl_toff,
  output logic          ofs_req,
  output logic          ss_done
);
  logic          run;
  logic          last;
  ss_state_t     state;
  logic [SW-1:0] step;

  assign run = en && supply_ok;

  ss_cycle_counter #(.STEP_CYCLES(STEP_CYCLES)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (!run || state != SS_RAMP),
    .adv  (cyc_tick),
    .last (last)
  );

  ss_step_fsm #(.NUM_STEPS(NUM_STEPS)) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .tick  (cyc_tick),
    .last  (last),
    .state (state),
    .step  (step)
  );

  ss_out_decode #(.NUM_STEPS(NUM_STEPS)) u_dec (
    .clk          (clk),
    .rst          (rst),
    .state        (state),
    .step         (step),
    .drv_en       (drv_en),
    .lo_precharge (lo_precharge),
    .ilim_code    (ilim_code),
    .dbl_toff     (dbl_toff),
    .ofs_req      (ofs_req),
    .ss_done      (ss_done)
  );

  // R2: a run edge out of idle always lands in precharge
  p_idle_to_boot_r2: assert property (@(posedge clk) disable iff (rst)
    (!drv_en && run) |=> (lo_precharge && drv_en && ilim_code == '0));
endmodule

// File: tb/sim_ss_sequencer.sv
module sim_ss_sequencer;
  logic clk = 1'b0;
  logic rst, cyc_tick, en, supply_ok;
  logic drv_en, lo_precharge, dbl_toff, ofs_req, ss_done;
  logic [1:0] ilim_code;

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  // model: 0 idle, 1 precharge, 2 ramp, 3 done
  int m_st = 0, m_step = 0, m_cnt = 0;

  always #2 clk = ~clk;

  ss_sequencer u0 (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .en(en), .supply_ok(supply_ok),
    .drv_en(drv_en), .lo_precharge(lo_precharge), .ilim_code(ilim_code),
    .dbl_toff(dbl_toff), .ofs_req(ofs_req), .ss_done(ss_done)
  );

  function automatic int exp_code(int st, int stp);
    if (st == 2) return stp;
    if (st == 3) return 3;
    return 0;
  endfunction

  function automatic string tag_of(int st);
    case (st)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, n_cyc);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag,  "ilim_code",    int'(ilim_code), exp_code(m_st, m_step));
    cmp("R8", "drv_en",       int'(drv_en), (m_st != 0) ? 1 : 0);
    cmp(tag,  "lo_precharge", int'(lo_precharge), (m_st == 1) ? 1 : 0);
    cmp(tag,  "dbl_toff",     int'(dbl_toff), (m_st == 2 && m_step == 0) ? 1 : 0);
    cmp(tag,  "ofs_req",      int'(ofs_req), (m_st == 2 && m_step == 0) ? 1 : 0);
    cmp(tag,  "ss_done",      int'(ss_done), (m_st == 3) ? 1 : 0);
  endtask

  // drive inputs, take one edge, update model, check after the edge
  task automatic cyc(logic t, logic e, logic s, string tag = "");
    logic run;
    cyc_tick = t; en = e; supply_ok = s;
    @(posedge clk);
    n_cyc++;
    run = e && s;
    if (!run) begin
      m_st = 0; m_step = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: m_st = 1;
        1: if (t) begin m_st = 2; m_step = 0; m_cnt = 0; end
        2: if (t) begin
             if (m_cnt == 109) begin
               m_cnt = 0;
               if (m_step == 3) m_st = 3; else m_step++;
             end else m_cnt++;
           end
        default: ;
      endcase
    end
    #1;
    if (tag != "")  check_all(tag);
    else if (!run)  check_all("R7");
    else            check_all(tag_of(m_st));
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic e, s;
    void'($urandom(32'd4242));
    rst = 1'b1; cyc_tick = 1'b0; en = 1'b1; supply_ok = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");                       // reset state
    rst = 1'b0;

    // R2/R3: enable, precharge waits for a tick, tick ends it uncounted
    cyc(0, 1, 1, "R2");
    repeat (5) cyc(0, 1, 1, "R2");
    cyc(1, 1, 1, "R3");
    // R4: full ramp with a tick every cycle, boundaries sampled each cycle
    repeat (109) cyc(1, 1, 1, "R4");
    cmp("R4", "still step0 at tick 109", int'(ilim_code), 0);
    cyc(1, 1, 1, "R4");
    cmp("R4", "step1 at tick 110", int'(ilim_code), 1);
    // R6: ticks absent hold the step and count
    repeat (60) cyc(0, 1, 1, "R6");
    repeat (329) cyc(1, 1, 1, "R4");
    cmp("R5", "not done at tick 439", int'(ss_done), 0);
    cyc(1, 1, 1, "R5");
    cmp("R5", "done at tick 440", int'(ss_done), 1);
    repeat (20) cyc(1, 1, 1, "R5");

    // R7: drop supply in done, then restart; count must start over
    cyc(1, 1, 0, "R7");
    cyc(1, 1, 1, "R2");
    cyc(1, 1, 1, "R3");
    repeat (439) cyc(1, 1, 1, "R4");
    // R7: lose supply one tick short of completion
    cyc(1, 1, 0, "R7");
    cyc(0, 1, 1, "R2");
    cyc(1, 1, 1, "R3");
    repeat (219) cyc(1, 1, 1, "R4");
    // R7: lose enable exactly on a step-boundary tick
    cyc(1, 0, 1, "R7");
    cmp("R7", "code after drop", int'(ilim_code), 0);
    repeat (4) cyc(1, 0, 0, "R7");

    // random phase
    e = 1'b1; s = 1'b1;
    for (int i = 0; i < 40000; i++) begin
      logic t;
      int dens;
      dens = (i / 4000) % 3;
      t = (dens == 0) ? 1'b1 : (dens == 1) ? (($urandom % 2) == 0) : (($urandom % 5) == 0);
      if (e && ($urandom % 3000) == 0) e = 1'b0;
      else if (!e && ($urandom % 8) == 0) e = 1'b1;
      if (s && ($urandom % 3000) == 0) s = 1'b0;
      else if (!s && ($urandom % 8) == 0) s = 1'b1;
      cyc(t, e, s);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule